// File: doc/BRIEF.md
# Serial Byte Receiver with Error Flags

This block turns an asynchronous serial input line into bytes for a host. It oversamples the line at sixteen ticks per bit. The tick comes in as a one-cycle strobe on `tick16_i`, produced by a baud generator outside the block. The line passes through a two-flop synchronizer. A falling edge then arms a start check, and each following bit is sampled at its centre: least significant bit first, then an optional parity bit, then the stop bit.

Start, parity and stop bits are always removed. A frame that passes both the parity check and the stop check places its data byte into a 32-entry receive queue. The host reads that queue in first-in first-out order. Three sticky flags report faults separately: a bad stop bit, a parity mismatch, and a good byte lost because the queue was full. The host clears all three with a status-read strobe.

Top module: `uart_rx_top`

## Requirements
- R1: Data bits are sampled at bit centres and assembled least significant bit first; the byte read by the host equals the eight data bits sent, without start, parity or stop bits.
- R2: A low pulse on the line that has returned high by the 8th tick after the falling edge is treated as noise: no byte is stored and no flag is set.
- R3: With `par_en_i`=1 one parity bit follows the data. `par_odd_i`=0 selects even parity, where the count of ones over data and parity is even. `par_odd_i`=1 selects odd parity. With `par_en_i`=0 the stop bit directly follows the data.
- R4: A parity mismatch sets `perr_o` and the byte is not stored.
- R5: A low line at the stop-bit centre sets `ferr_o` and the byte is not stored; the next well-formed frame is received normally.
- R6: A good byte that completes while the queue holds 32 bytes sets `ovr_o` and is dropped; the bytes already queued are kept unchanged.
- R7: The queue holds 32 bytes and returns them in arrival order. `rd_data_o` shows the oldest byte while `byte_rdy_o`=1, and a one-cycle `rd_en_i` pulse removes it. `byte_rdy_o` is 0 when the queue is empty.
- R8: The error flags stay set until a one-cycle `stat_rd_i` pulse, after which all three read 0.
- R9: After reset, `byte_rdy_o`, `ferr_o`, `perr_o` and `ovr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick16_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en_i | input | 1 | Removes the oldest queued byte |
| stat_rd_i | input | 1 | Status read; clears the error flags |
| rd_data_o | output | 8 | Oldest queued byte |
| byte_rdy_o | output | 1 | Queue holds at least one byte |
| ferr_o | output | 1 | Sticky framing error |
| perr_o | output | 1 | Sticky parity error |
| ovr_o | output | 1 | Sticky overrun error |

## Verification
A frame's result is due a few clock cycles after the stop-bit centre: two synchronizer stages, the sample register, then the queue write. The bench therefore samples the queue and the flags only once it has driven the whole stop bit, which is about half a bit period later. Read data is show-ahead, so each byte is compared in the cycle before its removal pulse, and `byte_rdy_o` is checked after the last pulse. A flag clear takes effect at the next clock edge, and the bench looks one cycle after the strobe.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int DATA_BITS = 8;
    localparam int Q_DEPTH   = 32;
    localparam int OVERSMP   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 perr;
        logic                 ferr;
    } rx_result_t;

    function automatic logic parity_bad(logic [DATA_BITS-1:0] d, logic pbit, logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            q_o    <= 1'b1;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DBITS = DATA_BITS,
    parameter int OSR   = OVERSMP
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    output logic       done_o,
    output rx_result_t res_o
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DBITS + 1);
    localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);
    localparam logic [BW-1:0] TOP_C  = BW'(DBITS - 1);

    rx_state_e        st;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bitn;
    logic [DBITS-1:0] shreg;
    logic             rx_prev;
    logic             par_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            rx_prev <= 1'b1;
            par_bit <= 1'b0;
            done_o  <= 1'b0;
            res_o   <= '0;
        end else begin
            done_o  <= 1'b0;
            rx_prev <= rx_i;
            case (st)
                ST_IDLE: begin
                    if (rx_prev && !rx_i) begin
                        st  <= ST_START;
                        cnt <= '0;
                    end
                end
                ST_START: begin
                    if (tick_i) begin
                        if (cnt == MID_C) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= rx_i ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick_i) begin
                        if (cnt == LAST_C) begin
                            cnt   <= '0;
                            shreg <= {rx_i, shreg[DBITS-1:1]};
                            if (bitn == TOP_C) st <= par_en_i ? ST_PAR : ST_STOP;
                            else               bitn <= bitn + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (tick_i) begin
                        if (cnt == LAST_C) begin
                            cnt     <= '0;
                            par_bit <= rx_i;
                            st      <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick_i) begin
                        if (cnt == LAST_C) begin
                            done_o     <= 1'b1;
                            res_o.data <= shreg;
                            res_o.ferr <= !rx_i;
                            res_o.perr <= par_en_i && parity_bad(shreg, par_bit, par_odd_i);
                            st         <= ST_IDLE;
                            cnt        <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2
    glitch_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START && tick_i && cnt == MID_C && rx_i) |=> (st == ST_IDLE && !done_o));

    // R1
    bit_index_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (bitn <= TOP_C));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wptr, rptr;
    logic [AW:0]      fill;

    assign fill    = wptr - rptr;
    assign empty_o = (fill == '0);
    assign full_o  = (fill == (AW+1)'(DEPTH));
    assign rdata_o = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_i && !full_o) mem[wptr[AW-1:0]] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_i && !full_o) wptr <= wptr + 1'b1;
            if (rd_i && !empty_o) rptr <= rptr + 1'b1;
        end
    end

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= (AW+1)'(DEPTH));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && empty_o) |=> $stable(rptr));

    // R6
    full_push_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && full_o && !rd_i) |=> $stable(wptr));
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       tick16_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       rd_en_i,
    input  logic       stat_rd_i,
    output logic [7:0] rd_data_o,
    output logic       byte_rdy_o,
    output logic       ferr_o,
    output logic       perr_o,
    output logic       ovr_o
);
    logic       rx_s;
    logic       done;
    rx_result_t res;
    logic       good, push, q_empty, q_full;
    logic       ferr_set, perr_set, ovr_set;

    uart_rx_sync sync_i (.clk(clk), .rst(rst), .d_i(rx_i), .q_o(rx_s));

    uart_rx_frame #(.DBITS(DATA_BITS), .OSR(OVERSMP)) frame_i (
        .clk(clk), .rst(rst), .tick_i(tick16_i), .rx_i(rx_s),
        .par_en_i(par_en_i), .par_odd_i(par_odd_i),
        .done_o(done), .res_o(res)
    );

    assign good     = done && !res.ferr && !res.perr;
    assign push     = good && !q_full;
    assign ferr_set = done && res.ferr;
    assign perr_set = done && res.perr;
    assign ovr_set  = good && q_full;

    uart_rx_fifo #(.WIDTH(DATA_BITS), .DEPTH(Q_DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .wr_i(push), .wdata_i(res.data),
        .rd_i(rd_en_i), .rdata_o(rd_data_o), .empty_o(q_empty), .full_o(q_full)
    );

    assign byte_rdy_o = !q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ferr_o <= 1'b0;
            perr_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            ferr_o <= ferr_set | (ferr_o & !stat_rd_i);
            perr_o <= perr_set | (perr_o & !stat_rd_i);
            ovr_o  <= ovr_set  | (ovr_o  & !stat_rd_i);
        end
    end

    // R6
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_o) |-> $past(done && q_full));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && !done) |=> (!ferr_o && !perr_o && !ovr_o));

    // R4
    bad_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (res.perr || res.ferr) && !rd_en_i) |=> $stable(byte_rdy_o));
endmodule

// File: tb/uart_rx_top_tb_top.sv
module uart_rx_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1, tick = 1'b0, pen = 1'b0, podd = 1'b0;
    logic       rd_en = 1'b0, stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       byte_rdy, ferr, perr, ovr;

    int total = 0;
    int bad   = 0;
    logic [7:0] expq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) tick <= ~tick;

    uart_rx_top dut_i (
        .clk(clk), .rst(rst), .rx_i(rx), .tick16_i(tick),
        .par_en_i(pen), .par_odd_i(podd), .rd_en_i(rd_en), .stat_rd_i(stat_rd),
        .rd_data_o(rd_data), .byte_rdy_o(byte_rdy),
        .ferr_o(ferr), .perr_o(perr), .ovr_o(ovr)
    );

    function automatic logic par_of(logic [7:0] d, logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(logic v);
        rx = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send(logic [7:0] d, logic bad_par, logic bad_stop);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (pen) drive_bit(par_of(d, podd) ^ bad_par);
        drive_bit(!bad_stop);
        rx = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_good(logic [7:0] d);
        send(d, 1'b0, 1'b0);
        expq.push_back(d);
    endtask

    task automatic drain(string tag);
        while (expq.size() > 0) begin
            logic [7:0] e;
            e = expq.pop_front();
            chk({tag, " byte_rdy"}, byte_rdy, 1);
            chk({tag, " data"}, rd_data, e);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        @(negedge clk);
        chk({tag, " R7 empty"}, byte_rdy, 0);
    endtask

    task automatic clear_flags();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 byte_rdy", byte_rdy, 0);
        chk("R9 flags", {ferr, perr, ovr}, 0);

        // R1 R3 random bytes in each parity mode
        for (int m = 0; m < 3; m++) begin
            pen  = (m != 0);
            podd = (m == 2);
            for (int k = 0; k < 6; k++) send_good(8'($urandom));
            chk("R3 no perr", perr, 0);
            drain("R1 R3 mode");
        end

        // R1 directed edge patterns, odd parity
        pen = 1'b1; podd = 1'b1;
        send_good(8'h00); send_good(8'hFF); send_good(8'h80); send_good(8'h01);
        drain("R1 directed");

        // R4 parity error, even parity
        podd = 1'b0;
        send(8'h5A, 1'b1, 1'b0);
        chk("R4 perr set", perr, 1);
        chk("R4 ferr clear", ferr, 0);
        chk("R4 not stored", byte_rdy, 0);
        repeat (50) @(negedge clk);
        chk("R8 perr sticky", perr, 1);
        clear_flags();
        chk("R8 perr cleared", perr, 0);

        // R5 framing error then recovery
        pen = 1'b0;
        send(8'hC3, 1'b0, 1'b1);
        chk("R5 ferr set", ferr, 1);
        chk("R5 not stored", byte_rdy, 0);
        send_good(8'h3C);
        drain("R5 recovery");
        clear_flags();
        chk("R8 ferr cleared", ferr, 0);

        // R2 short low pulse rejected
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R2 no byte", byte_rdy, 0);
        chk("R2 no flags", {ferr, perr, ovr}, 0);
        send_good(8'hA5);
        drain("R2 after glitch");

        // R6 R7 fill 32 then overrun
        for (int k = 0; k < 32; k++) send_good(8'($urandom));
        chk("R6 no ovr at 32", ovr, 0);
        send(8'hEE, 1'b0, 1'b0);
        chk("R6 ovr set", ovr, 1);
        chk("R6 other flags", {ferr, perr}, 0);
        drain("R6 R7 full queue");
        clear_flags();
        chk("R8 ovr cleared", ovr, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule